// File: doc/BRIEF.md
# Two-Lane Shift-Mask Accumulator Interpolator

This block is a small register-mapped arithmetic helper for address generation and table walks. It holds two accumulators, three bases and a configuration word for each of its two lanes. Each lane rotates its input word right, keeps a contiguous bit field, optionally sign-extends that field, and adds the outcome to its base. A third result adds the third base to both lanes' field values, so that a single read yields an address such as table start plus a row offset plus a column offset.

Software reaches everything through one word-wide read/write port. A peek read returns a result and changes nothing. A pop read returns the same value and, on the clock edge that ends the read, loads each accumulator from a lane result. Repeating pops therefore steps the accumulators forward with no explicit write. The lanes can swap their inputs or their write-back targets, and a lane can add its whole accumulator to its base, skipping the field, while the third result still uses the field values. All results are combinational functions of the stored registers.

Top module: `ilp_interp`

## Requirements
- R1: After reset, both accumulators and all three bases read 0, and both configuration words read 0x00007C00: shift 0, field low index 0, field high index 31, all flags clear. The configuration word packs shift in bits 4:0, field low index in bits 9:5, field high index in bits 14:10, sign flag in bit 15, input-swap flag in bit 16, write-back-swap flag in bit 17 and whole-add flag in bit 18. The word addresses are: 0 accumulator 0, 1 accumulator 1, 2 base 0, 3 base 1, 4 base 2, 5/6/7 pop of results 0/1/2, 8/9/10 peek of results 0/1/2, 11/12 configuration 0/1, 13/14 field value of lane 0/1.
- R2: Reading a lane's field-value address returns its input word rotated right by the shift amount (0 to 31), with every bit outside the inclusive index range from low to high cleared; low 0 with high 31 passes the whole rotated word.
- R3: With the sign flag set, every bit above the high index of the field value is a copy of the bit at the high index.
- R4: A peek of result 0 or 1 returns the lane base plus the lane's field value, and a peek leaves both accumulators unchanged.
- R5: A pop of any result returns the same value as the matching peek and then loads accumulator 0 with result 0 and accumulator 1 with result 1, so pops with accumulator 0 at 0 and base 0 at 9 return 9, 18, 27 and onward.
- R6: With the write-back-swap flag set in configuration 0, a pop loads accumulator 0 from result 1; with the flag set in configuration 1, a pop loads accumulator 1 from result 0.
- R7: With the input-swap flag set, a lane uses the other lane's accumulator as its input word.
- R8: Result 2 equals base 2 plus the field value of lane 0 plus the field value of lane 1, modulo 2^32.
- R9: With the whole-add flag set, a lane's result is its base plus its unmodified input word, while its field value and result 2 still use the rotated and masked field.
- R10: Writing a lane's field-value address adds the written word to that lane's accumulator instead of storing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| rd_en | input | 1 | Read strobe; a pop address updates accumulators at the next edge |
| addr | input | 4 | Word address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr and register state |

## Verification
A wrong accumulator or configuration bit shows on the very next read of any result or field value, since those are combinational from the stored state; a wrong write-back shows on the read that follows the faulty pop. The sweep over shift amounts, field bounds and the sign flag exposes a misplaced mask edge or sign bit as a wrong bit in the first field read of that setting. Stepping sequences of pops with the swap flags turn a misrouted write-back into a miscompare within one or two pops, and reads of accumulators after peeks catch any side effect of a peek at once.

// File: rtl/ilp_pkg.sv
package ilp_pkg;

   // Register word addresses of the interpolator.
   typedef enum logic [3:0] {
      A_ACC0  = 4'd0,
      A_ACC1  = 4'd1,
      A_BASE0 = 4'd2,
      A_BASE1 = 4'd3,
      A_BASE2 = 4'd4,
      A_POP0  = 4'd5,
      A_POP1  = 4'd6,
      A_POP2  = 4'd7,
      A_PEEK0 = 4'd8,
      A_PEEK1 = 4'd9,
      A_PEEK2 = 4'd10,
      A_CFG0  = 4'd11,
      A_CFG1  = 4'd12,
      A_RAW0  = 4'd13,
      A_RAW1  = 4'd14
   } reg_sel_e;

   localparam int unsigned SEL_W = 4;
   localparam int unsigned N_LANE = 2;

   function automatic logic is_pop(input reg_sel_e s);
      return (s == A_POP0) || (s == A_POP1) || (s == A_POP2);
   endfunction

   function automatic logic is_peek(input reg_sel_e s);
      return (s == A_PEEK0) || (s == A_PEEK1) || (s == A_PEEK2);
   endfunction

endpackage

// File: rtl/ilp_shift_mask.sv
module ilp_shift_mask #(
   parameter int unsigned DATA_W = 32,
   parameter bit          ROTATE = 1'b1,
   parameter int unsigned SH_W   = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] din,
   input  logic [SH_W-1:0]   shift,
   input  logic [SH_W-1:0]   fld_lo,
   input  logic [SH_W-1:0]   fld_hi,
   input  logic              sext,
   output logic [DATA_W-1:0] dout
);

   logic [DATA_W-1:0] shifted;
   logic [DATA_W-1:0] in_fld;
   logic [DATA_W-1:0] above;
   logic              top_bit;

   // Variant: circular rotate or plain logical shift.
   generate
      if (ROTATE) begin : g_rot
         logic [2*DATA_W-1:0] dbl;
         assign dbl     = {din, din} >> shift;
         assign shifted = dbl[DATA_W-1:0];
      end else begin : g_shr
         assign shifted = din >> shift;
      end
   endgenerate

   // Per-bit field membership and sign-fill region.
   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_bit
         assign in_fld[b] = (SH_W'(b) >= fld_lo) && (SH_W'(b) <= fld_hi);
         assign above[b]  = (SH_W'(b) > fld_hi);
      end
   endgenerate

   assign top_bit = sext & in_fld[fld_hi] & shifted[fld_hi];

   always_comb begin
      for (int b = 0; b < DATA_W; b++) begin
         if (in_fld[b])
            dout[b] = shifted[b];
         else if (above[b])
            dout[b] = top_bit;
         else
            dout[b] = 1'b0;
      end
   end

endmodule

// File: rtl/ilp_lane.sv
module ilp_lane #(
   parameter int unsigned DATA_W = 32,
   parameter bit          ROTATE = 1'b1,
   parameter int unsigned SH_W   = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] acc_own,
   input  logic [DATA_W-1:0] acc_other,
   input  logic [DATA_W-1:0] base,
   input  logic [SH_W-1:0]   shift,
   input  logic [SH_W-1:0]   fld_lo,
   input  logic [SH_W-1:0]   fld_hi,
   input  logic              sext,
   input  logic              swap_in,
   input  logic              whole_add,
   output logic [DATA_W-1:0] fld_val,
   output logic [DATA_W-1:0] result
);

   logic [DATA_W-1:0] src;
   logic [DATA_W-1:0] addend;

   assign src = swap_in ? acc_other : acc_own;

   ilp_shift_mask #(
      .DATA_W (DATA_W),
      .ROTATE (ROTATE),
      .SH_W   (SH_W)
   ) u_sm (
      .din    (src),
      .shift  (shift),
      .fld_lo (fld_lo),
      .fld_hi (fld_hi),
      .sext   (sext),
      .dout   (fld_val)
   );

   assign addend = whole_add ? src : fld_val;
   assign result = base + addend;

endmodule

// File: rtl/ilp_rd_mux.sv
module ilp_rd_mux #(
   parameter int unsigned DATA_W = 32
) (
   input  logic                 hit,
   input  ilp_pkg::reg_sel_e    sel,
   input  logic [DATA_W-1:0]    acc0,
   input  logic [DATA_W-1:0]    acc1,
   input  logic [DATA_W-1:0]    base0,
   input  logic [DATA_W-1:0]    base1,
   input  logic [DATA_W-1:0]    base2,
   input  logic [DATA_W-1:0]    res0,
   input  logic [DATA_W-1:0]    res1,
   input  logic [DATA_W-1:0]    res2,
   input  logic [DATA_W-1:0]    fld0,
   input  logic [DATA_W-1:0]    fld1,
   input  logic [DATA_W-1:0]    cfg0,
   input  logic [DATA_W-1:0]    cfg1,
   output logic [DATA_W-1:0]    rdata
);
   import ilp_pkg::*;

   always_comb begin
      rdata = '0;
      if (hit) begin
         unique case (sel)
            A_ACC0:           rdata = acc0;
            A_ACC1:           rdata = acc1;
            A_BASE0:          rdata = base0;
            A_BASE1:          rdata = base1;
            A_BASE2:          rdata = base2;
            A_POP0, A_PEEK0:  rdata = res0;
            A_POP1, A_PEEK1:  rdata = res1;
            A_POP2, A_PEEK2:  rdata = res2;
            A_CFG0:           rdata = cfg0;
            A_CFG1:           rdata = cfg1;
            A_RAW0:           rdata = fld0;
            A_RAW1:           rdata = fld1;
            default:          rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/ilp_interp.sv
module ilp_interp #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 4,
   parameter bit          ROTATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   import ilp_pkg::*;

   localparam int unsigned SH_W     = $clog2(DATA_W);
   localparam int unsigned SH_LO    = 0;
   localparam int unsigned LO_LO    = SH_W;
   localparam int unsigned HI_LO    = 2 * SH_W;
   localparam int unsigned B_SEXT   = 3 * SH_W;
   localparam int unsigned B_SWIN   = B_SEXT + 1;
   localparam int unsigned B_SWOUT  = B_SEXT + 2;
   localparam int unsigned B_WHOLE  = B_SEXT + 3;
   localparam int unsigned CFG_W    = B_WHOLE + 1;
   localparam logic [CFG_W-1:0] CFG_RST = CFG_W'(DATA_W - 1) << HI_LO;

   // Elaboration-time parameter checks.
   generate
      if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_w
         $error("ilp_interp: DATA_W must be a power of two of at least 8");
      end
      if (ADDR_W < SEL_W) begin : g_bad_a
         $error("ilp_interp: ADDR_W too narrow for the register map");
      end
      if (CFG_W > DATA_W) begin : g_bad_c
         $error("ilp_interp: configuration word wider than data word");
      end
   endgenerate

   logic [DATA_W-1:0] acc_q  [N_LANE];
   logic [DATA_W-1:0] base_q [N_LANE+1];
   logic [CFG_W-1:0]  cfg_q  [N_LANE];
   logic [DATA_W-1:0] fld_w  [N_LANE];
   logic [DATA_W-1:0] res_w  [N_LANE];
   logic [DATA_W-1:0] res2_w;

   // Address decode.
   logic     hit;
   reg_sel_e sel;

   generate
      if (ADDR_W > SEL_W) begin : g_wide_addr
         assign hit = (addr[ADDR_W-1:SEL_W] == '0) && (addr[SEL_W-1:0] <= 4'd14);
      end else begin : g_exact_addr
         assign hit = (addr[SEL_W-1:0] <= 4'd14);
      end
   endgenerate
   assign sel = reg_sel_e'(addr[SEL_W-1:0]);

   // Lanes.
   generate
      for (genvar g = 0; g < N_LANE; g++) begin : g_lane
         ilp_lane #(
            .DATA_W (DATA_W),
            .ROTATE (ROTATE),
            .SH_W   (SH_W)
         ) u_lane (
            .acc_own   (acc_q[g]),
            .acc_other (acc_q[N_LANE-1-g]),
            .base      (base_q[g]),
            .shift     (cfg_q[g][SH_LO +: SH_W]),
            .fld_lo    (cfg_q[g][LO_LO +: SH_W]),
            .fld_hi    (cfg_q[g][HI_LO +: SH_W]),
            .sext      (cfg_q[g][B_SEXT]),
            .swap_in   (cfg_q[g][B_SWIN]),
            .whole_add (cfg_q[g][B_WHOLE]),
            .fld_val   (fld_w[g]),
            .result    (res_w[g])
         );
      end
   endgenerate

   assign res2_w = base_q[2] + fld_w[0] + fld_w[1];

   // Register state.
   logic do_wr, do_pop;
   assign do_wr  = wr_en && hit;
   assign do_pop = rd_en && !wr_en && hit && is_pop(sel);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N_LANE; i++) begin
            acc_q[i] <= '0;
            cfg_q[i] <= CFG_RST;
         end
         for (int i = 0; i <= N_LANE; i++) begin
            base_q[i] <= '0;
         end
      end else if (do_wr) begin
         case (sel)
            A_ACC0:  acc_q[0]  <= wdata;
            A_ACC1:  acc_q[1]  <= wdata;
            A_BASE0: base_q[0] <= wdata;
            A_BASE1: base_q[1] <= wdata;
            A_BASE2: base_q[2] <= wdata;
            A_CFG0:  cfg_q[0]  <= wdata[CFG_W-1:0];
            A_CFG1:  cfg_q[1]  <= wdata[CFG_W-1:0];
            A_RAW0:  acc_q[0]  <= acc_q[0] + wdata;
            A_RAW1:  acc_q[1]  <= acc_q[1] + wdata;
            default: ;
         endcase
      end else if (do_pop) begin
         acc_q[0] <= cfg_q[0][B_SWOUT] ? res_w[1] : res_w[0];
         acc_q[1] <= cfg_q[1][B_SWOUT] ? res_w[0] : res_w[1];
      end
   end

   ilp_rd_mux #(
      .DATA_W (DATA_W)
   ) u_rd (
      .hit   (hit),
      .sel   (sel),
      .acc0  (acc_q[0]),
      .acc1  (acc_q[1]),
      .base0 (base_q[0]),
      .base1 (base_q[1]),
      .base2 (base_q[2]),
      .res0  (res_w[0]),
      .res1  (res_w[1]),
      .res2  (res2_w),
      .fld0  (fld_w[0]),
      .fld1  (fld_w[1]),
      .cfg0  (DATA_W'(cfg_q[0])),
      .cfg1  (DATA_W'(cfg_q[1])),
      .rdata (rdata)
   );

endmodule

// File: rtl/ilp_interp_chk.sv
module ilp_interp_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] acc0,
   input logic [DATA_W-1:0] acc1,
   input logic [DATA_W-1:0] res0,
   input logic [DATA_W-1:0] res1,
   input logic [DATA_W-1:0] res2,
   input logic [DATA_W-1:0] fld0,
   input logic [DATA_W-1:0] fld1,
   input logic [DATA_W-1:0] base2,
   input logic              swout0,
   input logic              swout1
);

   localparam logic [ADDR_W-1:0] AD_POP0  = ADDR_W'(5);
   localparam logic [ADDR_W-1:0] AD_POP1  = ADDR_W'(6);
   localparam logic [ADDR_W-1:0] AD_POP2  = ADDR_W'(7);
   localparam logic [ADDR_W-1:0] AD_PEEK0 = ADDR_W'(8);
   localparam logic [ADDR_W-1:0] AD_PEEK2 = ADDR_W'(10);
   localparam logic [ADDR_W-1:0] AD_RAW0  = ADDR_W'(13);
   localparam logic [ADDR_W-1:0] AD_RAW1  = ADDR_W'(14);

   logic pop_hit, peek_hit;
   assign pop_hit  = rd_en && !wr_en && (addr >= AD_POP0) && (addr <= AD_POP2);
   assign peek_hit = rd_en && !wr_en && (addr >= AD_PEEK0) && (addr <= AD_PEEK2);

   // R4: a peek leaves both accumulators as they were.
   p_peek_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      peek_hit |=> ($stable(acc0) && $stable(acc1)));

   // R5: pop loads each accumulator with its own lane result.
   p_pop_own0_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_hit && !swout0) |=> (acc0 == $past(res0)));

   p_pop_own1_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_hit && !swout1) |=> (acc1 == $past(res1)));

   // R6: swapped write-back.
   p_pop_swap0_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_hit && swout0) |=> (acc0 == $past(res1)));

   p_pop_swap1_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_hit && swout1) |=> (acc1 == $past(res0)));

   // R8: third result is the sum across both lanes.
   p_sum_three_r8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> (res2 == base2 + fld0 + fld1));

   // R10: a field-value write accumulates.
   p_raw_add0_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == AD_RAW0) |=> (acc0 == $past(acc0) + $past(wdata)));

   p_raw_add1_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == AD_RAW1) |=> (acc1 == $past(acc1) + $past(wdata)));

endmodule

bind ilp_interp ilp_interp_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .wr_en  (wr_en),
   .rd_en  (rd_en),
   .addr   (addr),
   .wdata  (wdata),
   .acc0   (acc_q[0]),
   .acc1   (acc_q[1]),
   .res0   (res_w[0]),
   .res1   (res_w[1]),
   .res2   (res2_w),
   .fld0   (fld_w[0]),
   .fld1   (fld_w[1]),
   .base2  (base_q[2]),
   .swout0 (cfg_q[0][B_SWOUT]),
   .swout1 (cfg_q[1][B_SWOUT])
);

// File: tb/tb_ilp_interp.sv
module tb_ilp_interp;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   ilp_interp dut (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .rd_en (rd_en),
      .addr  (addr),
      .wdata (wdata),
      .rdata (rdata)
   );

   localparam logic [3:0] ACC0 = 0, ACC1 = 1, BASE0 = 2, BASE1 = 3, BASE2 = 4,
                          POP0 = 5, POP1 = 6, POP2 = 7, PEEK0 = 8, PEEK1 = 9,
                          PEEK2 = 10, CFG0 = 11, CFG1 = 12, RAW0 = 13, RAW1 = 14;

   function automatic logic [31:0] mk_cfg(int sh, int lo, int hi, bit sg,
                                          bit swin, bit swout, bit whole);
      return 32'(sh) | (32'(lo) << 5) | (32'(hi) << 10) | (32'(sg) << 15) |
             (32'(swin) << 16) | (32'(swout) << 17) | (32'(whole) << 18);
   endfunction

   function automatic logic [31:0] m_fld(logic [31:0] a, int sh, int lo, int hi, bit sg);
      logic [31:0] r;
      logic        s;
      r = (a >> sh) | (a << ((32 - sh) % 32));
      for (int i = 0; i < 32; i++)
         if (i < lo || i > hi) r[i] = 1'b0;
      s = sg && (lo <= hi) && r[hi];
      for (int i = 0; i < 32; i++)
         if (i > hi) r[i] = s;
      return r;
   endfunction

   task automatic check(string req, logic [31:0] got, logic [31:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %08h expected %08h", req, got, exp);
      end
   endtask

   task automatic bus_wr(logic [3:0] a, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      #1 d = rdata;
      @(posedge clk); #1;
      rd_en = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog: got hang expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, e0, e1, p0, p1, f0, f1;
      logic [31:0] pats [2];
      pats[0] = 32'h1234abcd;
      pats[1] = 32'h8f0c_7351;

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset values
      bus_rd(ACC0, v);  check("R1 acc0", v, 32'h0);
      bus_rd(ACC1, v);  check("R1 acc1", v, 32'h0);
      bus_rd(BASE0, v); check("R1 base0", v, 32'h0);
      bus_rd(BASE1, v); check("R1 base1", v, 32'h0);
      bus_rd(BASE2, v); check("R1 base2", v, 32'h0);
      bus_rd(CFG0, v);  check("R1 cfg0", v, 32'h00007C00);
      bus_rd(CFG1, v);  check("R1 cfg1", v, 32'h00007C00);

      // R2 / R3: sweep of shift, field bounds and sign flag on lane 0
      for (int p = 0; p < 2; p++) begin
         bus_wr(ACC0, pats[p]);
         for (int sh = 0; sh < 32; sh += 3)
            for (int lo = 0; lo < 32; lo += 4)
               for (int hi = lo; hi < 32; hi += 5)
                  for (int sg = 0; sg < 2; sg++) begin
                     bus_wr(CFG0, mk_cfg(sh, lo, hi, sg[0], 0, 0, 0));
                     bus_rd(RAW0, v);
                     check(sg ? "R3 sign field" : "R2 field", v,
                           m_fld(pats[p], sh, lo, hi, sg[0]));
                  end
      end
      bus_wr(CFG0, mk_cfg(0, 0, 31, 0, 0, 0, 0));
      bus_rd(RAW0, v); check("R2 full word", v, pats[1]);
      bus_wr(CFG0, mk_cfg(0, 4, 7, 1, 0, 0, 0));
      bus_wr(ACC0, 32'h0000_00C0);
      bus_rd(RAW0, v); check("R3 negative nibble", v, 32'hFFFF_FFC0);

      // R4: peek returns base + field and has no side effect
      bus_wr(CFG0, mk_cfg(0, 0, 31, 0, 0, 0, 0));
      bus_wr(ACC0, 32'h0000_1000);
      bus_wr(BASE0, 32'h0000_0234);
      for (int k = 0; k < 3; k++) begin
         bus_rd(PEEK0, v); check("R4 peek0", v, 32'h0000_1234);
      end
      bus_rd(ACC0, v); check("R4 acc0 after peeks", v, 32'h0000_1000);

      // R5: pops step by base
      bus_wr(ACC0, 0);
      bus_wr(BASE0, 9);
      for (int k = 1; k <= 10; k++) begin
         bus_rd(POP0, v); check("R5 pop0 step", v, 32'(9 * k));
      end
      bus_rd(ACC0, v); check("R5 acc0 after pops", v, 32'd90);

      // R6: swapped write-back on both lanes
      bus_wr(CFG0, mk_cfg(0, 0, 31, 0, 0, 1, 0));
      bus_wr(CFG1, mk_cfg(0, 0, 31, 0, 0, 1, 0));
      bus_wr(ACC0, 123); bus_wr(ACC1, 456);
      bus_wr(BASE0, 1);  bus_wr(BASE1, 0);
      e0 = 123; e1 = 456;
      for (int k = 0; k < 8; k++) begin
         bus_rd(PEEK0, v); check("R6 peek0", v, e0 + 1);
         bus_rd(POP1, v);  check("R6 pop1", v, e1);
         p0 = e0 + 1; p1 = e1;
         e0 = p1; e1 = p0;
      end
      bus_rd(ACC0, v); check("R6 acc0", v, e0);
      bus_rd(ACC1, v); check("R6 acc1", v, e1);

      // R7: lane 1 reads accumulator 0
      bus_wr(CFG0, mk_cfg(0, 0, 31, 0, 0, 0, 0));
      bus_wr(CFG1, mk_cfg(4, 0, 31, 0, 1, 0, 0));
      bus_wr(ACC0, 32'h1234abcd); bus_wr(ACC1, 0);
      bus_wr(BASE1, 32'h10);
      bus_rd(RAW1, v);  check("R7 raw1 swapped", v, 32'hD1234ABC);
      bus_rd(PEEK1, v); check("R7 peek1 swapped", v, 32'hD1234ACC);

      // R8: third result and pop write-back of both lanes
      bus_wr(CFG0, mk_cfg(8, 0, 7, 0, 0, 0, 0));
      bus_wr(CFG1, mk_cfg(0, 2, 5, 1, 0, 0, 0));
      bus_wr(ACC0, 32'h0000_5A00); bus_wr(ACC1, 32'h0000_0030);
      bus_wr(BASE0, 32'h100); bus_wr(BASE1, 32'h200); bus_wr(BASE2, 32'h4000_0000);
      f0 = m_fld(32'h5A00, 8, 0, 7, 0); f1 = m_fld(32'h30, 0, 2, 5, 1);
      bus_rd(PEEK2, v); check("R8 peek2", v, 32'h4000_0000 + f0 + f1);
      bus_rd(POP2, v);  check("R8 pop2", v, 32'h4000_0000 + f0 + f1);
      bus_rd(ACC0, v);  check("R8 acc0 after pop2", v, 32'h100 + f0);
      bus_rd(ACC1, v);  check("R8 acc1 after pop2", v, 32'h200 + f1);

      // R9: whole-add keeps the field for result 2
      bus_wr(CFG0, mk_cfg(16, 0, 1, 0, 0, 0, 1));
      bus_wr(CFG1, mk_cfg(0, 0, 31, 0, 0, 0, 0));
      bus_wr(ACC0, 32'h0003_5000); bus_wr(ACC1, 32'h7);
      bus_wr(BASE0, 32'h100); bus_wr(BASE2, 32'h1000);
      bus_rd(PEEK0, v); check("R9 peek0 whole", v, 32'h0003_5100);
      bus_rd(RAW0, v);  check("R9 raw0 field", v, 32'h3);
      bus_rd(PEEK2, v); check("R9 peek2 field sum", v, 32'h100A);

      // R10: field-value write accumulates
      bus_wr(RAW0, 32'h10);
      bus_rd(ACC0, v); check("R10 acc0 add", v, 32'h0003_5010);
      bus_wr(RAW1, 32'hFFFF_FFFF);
      bus_rd(ACC1, v); check("R10 acc1 add", v, 32'h6);

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule